// File: doc/BRIEF.md
# Palette RGB Triplet Access Port

This block holds a color lookup table of 256 entries, each entry made of an 8-bit red, an 8-bit green and an 8-bit blue value. Software reaches the table through a small set of byte-wide registers. It loads a start index and then streams color bytes in the order red, green, blue. After every third byte the index moves to the next entry, so a run of consecutive entries can be loaded or dumped without setting the index again. Writing uses one index and reading uses another. A single mode flag, set by whichever index was loaded last, decides which direction of streaming is active.

The block also has a pixel mask register and a status register that reports the current mode. It has a lookup port for a pixel pipeline. This port takes a pixel index, ANDs it with the mask, and returns the 24-bit color of that entry in the same cycle. Each register access is one cycle long: the caller asserts a strobe together with the offset, the direction and the data. Read data is valid in that same cycle, and any side effect of the access takes effect at the clock edge that ends the cycle.

Top module: `palette_port`

## Requirements
- R1: After reset the write index reads 0, the pixel mask reads 0, the color phase is red and write streaming is selected, so the status register reads 3. The table contents are not cleared by reset.
- R2: A write to offset 0x8 loads the write index from the data byte, sets the phase back to red and selects write streaming. Any partly written triplet is abandoned.
- R3: A write to offset 0xA during write streaming stores the byte into the red, green or blue part of the entry at the write index, following the phase. After blue, the phase goes back to red and the write index increments, wrapping from 255 to 0.
- R4: A write to offset 0xE loads the read index, sets the phase back to red and selects read streaming, so the status register reads 0.
- R5: A read at offset 0x2 during read streaming returns the red, green or blue part of the entry at the read index, following the phase. After blue, the read index increments, wrapping from 255 to 0.
- R6: A read at offset 0x0 returns the current write index.
- R7: A write to offset 0xC loads the pixel mask, and a read at offset 0x4 returns it.
- R8: A read at offset 0x6 returns 0 while read streaming is selected and 3 while write streaming is selected.
- R9: Color accesses in the wrong mode have no effect. A write to 0xA during read streaming changes neither the table nor the phase. A read at 0x2 during write streaming returns 0 and does not advance the phase.
- R10: lookup_rgb always shows the entry at (lookup_idx AND mask), with red in bits 23:16, green in bits 15:8 and blue in bits 7:0. A color write becomes visible there at the clock edge that ends the write cycle.
- R11: acc_rdata is 0 when there is no read strobe, and also for a read at any offset other than 0x0, 0x2, 0x4 or 0x6. A write to any offset other than 0x8, 0xA, 0xC or 0xE changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; it is released synchronously inside the block |
| acc_valid | input | 1 | Register access strobe, one cycle per access |
| acc_write | input | 1 | 1 for a write, 0 for a read |
| acc_off | input | 4 | Register offset |
| acc_wdata | input | 8 | Write data byte |
| acc_rdata | output | 8 | Read data, valid in the strobe cycle |
| lookup_idx | input | 8 | Pixel index for the lookup port |
| lookup_rgb | output | 24 | Color of the masked entry, as {red, green, blue} |

## Verification
The lookup port reads the table combinationally, and the register port writes into it at the clock edge. The two can therefore address the same entry in the same cycle. The bench provokes this by pointing lookup_idx at an entry while it streams that entry's blue byte. Part-way through the write cycle it expects the new red and green values with the old blue. Just after the edge it expects the full new triplet. A second case is a color write in the wrong mode arriving on the same entry that an index load has just repointed. In that case both the bytes read back afterwards and the phase they come out in are checked.

// File: rtl/pal_pkg.sv
package pal_pkg;

  localparam int unsigned OFS_W = 4;
  localparam int unsigned N_CH  = 3;

  // Register offsets: reads on the low half, writes on the high half
  localparam logic [OFS_W-1:0] OFS_WIDX_RD  = 4'h0;
  localparam logic [OFS_W-1:0] OFS_COLOR_RD = 4'h2;
  localparam logic [OFS_W-1:0] OFS_MASK_RD  = 4'h4;
  localparam logic [OFS_W-1:0] OFS_MODE_RD  = 4'h6;
  localparam logic [OFS_W-1:0] OFS_WIDX_WR  = 4'h8;
  localparam logic [OFS_W-1:0] OFS_COLOR_WR = 4'hA;
  localparam logic [OFS_W-1:0] OFS_MASK_WR  = 4'hC;
  localparam logic [OFS_W-1:0] OFS_RIDX_WR  = 4'hE;

  // Status codes reported at OFS_MODE_RD
  localparam int unsigned MODE_CODE_RD = 0;
  localparam int unsigned MODE_CODE_WR = 3;

  typedef enum logic [1:0] {
    PH_RED   = 2'd0,
    PH_GREEN = 2'd1,
    PH_BLUE  = 2'd2
  } phase_e;

endpackage

// File: rtl/pal_rst_sync.sv
module pal_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/pal_ctrl.sv
module pal_ctrl
  import pal_pkg::*;
#(
  parameter int unsigned IDX_W = 8,
  parameter int unsigned CH_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic             acc_write,
  input  logic [OFS_W-1:0] acc_off,
  input  logic [CH_W-1:0]  acc_wdata,
  output logic [IDX_W-1:0] widx,
  output logic [IDX_W-1:0] ridx,
  output phase_e           phase,
  output logic             rd_mode,
  output logic [CH_W-1:0]  mask,
  output logic             col_we,
  output logic [N_CH-1:0]  col_sel
);

  logic [IDX_W-1:0] widx_q, widx_n, ridx_q, ridx_n;
  phase_e           phase_q, phase_n;
  logic             rdmode_q, rdmode_n;
  logic [CH_W-1:0]  mask_q;

  logic widx_en, ridx_en, phase_en, mode_en, mask_en;
  logic wr_hit, rd_hit;
  logic ld_widx, ld_ridx, ld_mask;
  logic col_wr_ok, col_rd_ok, step, last_ch;

  // Access decode
  always_comb begin
    wr_hit    = acc_valid && acc_write;
    rd_hit    = acc_valid && !acc_write;
    ld_widx   = wr_hit && (acc_off == OFS_WIDX_WR);
    ld_ridx   = wr_hit && (acc_off == OFS_RIDX_WR);
    ld_mask   = wr_hit && (acc_off == OFS_MASK_WR);
    col_wr_ok = wr_hit && (acc_off == OFS_COLOR_WR) && !rdmode_q;
    col_rd_ok = rd_hit && (acc_off == OFS_COLOR_RD) && rdmode_q;
    step      = col_wr_ok || col_rd_ok;
    last_ch   = (phase_q == PH_BLUE);
  end

  // Next state and clock enables
  always_comb begin
    widx_n   = widx_q;
    ridx_n   = ridx_q;
    phase_n  = phase_q;
    rdmode_n = rdmode_q;
    widx_en  = 1'b0;
    ridx_en  = 1'b0;
    phase_en = 1'b0;
    mode_en  = 1'b0;
    mask_en  = ld_mask;
    if (ld_widx) begin
      widx_n   = acc_wdata[IDX_W-1:0];
      phase_n  = PH_RED;
      rdmode_n = 1'b0;
      widx_en  = 1'b1;
      phase_en = 1'b1;
      mode_en  = 1'b1;
    end else if (ld_ridx) begin
      ridx_n   = acc_wdata[IDX_W-1:0];
      phase_n  = PH_RED;
      rdmode_n = 1'b1;
      ridx_en  = 1'b1;
      phase_en = 1'b1;
      mode_en  = 1'b1;
    end else if (step) begin
      phase_en = 1'b1;
      phase_n  = last_ch ? PH_RED : phase_e'(phase_q + 2'd1);
      if (last_ch && col_wr_ok) begin
        widx_n  = widx_q + 1'b1;
        widx_en = 1'b1;
      end
      if (last_ch && col_rd_ok) begin
        ridx_n  = ridx_q + 1'b1;
        ridx_en = 1'b1;
      end
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      widx_q   <= '0;
      ridx_q   <= '0;
      phase_q  <= PH_RED;
      rdmode_q <= 1'b0;
      mask_q   <= '0;
    end else begin
      if (widx_en)  widx_q   <= widx_n;
      if (ridx_en)  ridx_q   <= ridx_n;
      if (phase_en) phase_q  <= phase_n;
      if (mode_en)  rdmode_q <= rdmode_n;
      if (mask_en)  mask_q   <= acc_wdata;
    end
  end

  // Component select, one bit per channel
  always_comb begin
    col_sel = '0;
    for (int c = 0; c < int'(N_CH); c++) begin
      col_sel[c] = (int'(phase_q) == c);
    end
  end

  assign col_we  = col_wr_ok;
  assign widx    = widx_q;
  assign ridx    = ridx_q;
  assign phase   = phase_q;
  assign rd_mode = rdmode_q;
  assign mask    = mask_q;

  p_phase_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q != 2'd3);

  p_widx_adv_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (col_wr_ok && phase_q == PH_BLUE) |=> (widx_q == $past(widx_q) + 1'b1));

  p_ridx_adv_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (col_rd_ok && phase_q == PH_BLUE) |=> (ridx_q == $past(ridx_q) + 1'b1));

  p_wload_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && acc_off == OFS_WIDX_WR) |=>
      (phase_q == PH_RED && !rdmode_q && widx_q == $past(acc_wdata[IDX_W-1:0])));

  p_rload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && acc_off == OFS_RIDX_WR) |=>
      (phase_q == PH_RED && rdmode_q && ridx_q == $past(acc_wdata[IDX_W-1:0])));

  p_wrong_mode_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && acc_off == OFS_COLOR_WR && rdmode_q) |=> $stable(phase_q));

endmodule

// File: rtl/pal_store.sv
module pal_store
  import pal_pkg::*;
#(
  parameter int unsigned IDX_W = 8,
  parameter int unsigned CH_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  logic [N_CH-1:0]           sel,
  input  logic [IDX_W-1:0]          widx,
  input  logic [CH_W-1:0]           wdata,
  input  logic [IDX_W-1:0]          ridx,
  input  logic [IDX_W-1:0]          lu_idx,
  output logic [N_CH-1:0][CH_W-1:0] rd_rgb,
  output logic [N_CH-1:0][CH_W-1:0] lu_rgb
);

  localparam int unsigned DEPTH = 1 << IDX_W;

  for (genvar ch = 0; ch < int'(N_CH); ch++) begin : g_ch
    logic [CH_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (we && sel[ch]) begin
        mem[widx] <= wdata;
      end
    end

    assign rd_rgb[ch] = mem[ridx];
    assign lu_rgb[ch] = mem[lu_idx];
  end

  p_sel_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> ($countones(sel) == 1));

endmodule

// File: rtl/pal_rmux.sv
module pal_rmux
  import pal_pkg::*;
#(
  parameter int unsigned IDX_W = 8,
  parameter int unsigned CH_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      acc_valid,
  input  logic                      acc_write,
  input  logic [OFS_W-1:0]          acc_off,
  input  logic [IDX_W-1:0]          widx,
  input  logic [CH_W-1:0]           mask,
  input  logic                      rd_mode,
  input  phase_e                    phase,
  input  logic [N_CH-1:0][CH_W-1:0] rd_rgb,
  output logic [CH_W-1:0]           rdata
);

  logic rd_hit;

  always_comb begin
    rd_hit = acc_valid && !acc_write;
    rdata  = '0;
    if (rd_hit) begin
      case (acc_off)
        OFS_WIDX_RD:  rdata = CH_W'(widx);
        OFS_COLOR_RD: rdata = rd_mode ? rd_rgb[phase] : '0;
        OFS_MASK_RD:  rdata = mask;
        OFS_MODE_RD:  rdata = rd_mode ? CH_W'(MODE_CODE_RD) : CH_W'(MODE_CODE_WR);
        default:      rdata = '0;
      endcase
    end
  end

  p_status_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && acc_off == OFS_MODE_RD) |-> (rdata == CH_W'(3) || rdata == '0));

  p_wrong_mode_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && acc_off == OFS_COLOR_RD && !rd_mode) |-> (rdata == '0));

endmodule

// File: rtl/palette_port.sv
module palette_port
  import pal_pkg::*;
#(
  parameter int unsigned IDX_W = 8,
  parameter int unsigned CH_W  = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 acc_valid,
  input  logic                 acc_write,
  input  logic [OFS_W-1:0]     acc_off,
  input  logic [CH_W-1:0]      acc_wdata,
  output logic [CH_W-1:0]      acc_rdata,
  input  logic [IDX_W-1:0]     lookup_idx,
  output logic [N_CH*CH_W-1:0] lookup_rgb
);

  logic                      rst_sync_n;
  logic [IDX_W-1:0]          widx, ridx, lu_addr;
  phase_e                    phase;
  logic                      rd_mode;
  logic [CH_W-1:0]           mask;
  logic                      col_we;
  logic [N_CH-1:0]           col_sel;
  logic [N_CH-1:0][CH_W-1:0] rd_rgb, lu_rgb;

  pal_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pal_ctrl #(.IDX_W(IDX_W), .CH_W(CH_W)) i_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_off   (acc_off),
    .acc_wdata (acc_wdata),
    .widx      (widx),
    .ridx      (ridx),
    .phase     (phase),
    .rd_mode   (rd_mode),
    .mask      (mask),
    .col_we    (col_we),
    .col_sel   (col_sel)
  );

  assign lu_addr = lookup_idx & mask[IDX_W-1:0];

  pal_store #(.IDX_W(IDX_W), .CH_W(CH_W)) i_store (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .we     (col_we),
    .sel    (col_sel),
    .widx   (widx),
    .wdata  (acc_wdata),
    .ridx   (ridx),
    .lu_idx (lu_addr),
    .rd_rgb (rd_rgb),
    .lu_rgb (lu_rgb)
  );

  pal_rmux #(.IDX_W(IDX_W), .CH_W(CH_W)) i_rmux (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_off   (acc_off),
    .widx      (widx),
    .mask      (mask),
    .rd_mode   (rd_mode),
    .phase     (phase),
    .rd_rgb    (rd_rgb),
    .rdata     (acc_rdata)
  );

  // Red in the top byte, blue in the bottom byte
  for (genvar ch = 0; ch < int'(N_CH); ch++) begin : g_pack
    assign lookup_rgb[(N_CH-ch)*CH_W-1 -: CH_W] = lu_rgb[ch];
  end

  p_idle_zero_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !acc_valid |-> (acc_rdata == '0));

endmodule

// File: tb/test_palette_port.sv
module test_palette_port;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic        acc_write = 1'b0;
  logic [3:0]  acc_off = 4'h0;
  logic [7:0]  acc_wdata = 8'h00;
  logic [7:0]  acc_rdata;
  logic [7:0]  lookup_idx = 8'h00;
  logic [23:0] lookup_rgb;

  int checks = 0;
  int errors = 0;
  logic [7:0] m_r [256];
  logic [7:0] m_g [256];
  logic [7:0] m_b [256];

  always #5 clk = ~clk;

  palette_port i_palette_port (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_valid  (acc_valid),
    .acc_write  (acc_write),
    .acc_off    (acc_off),
    .acc_wdata  (acc_wdata),
    .acc_rdata  (acc_rdata),
    .lookup_idx (lookup_idx),
    .lookup_rgb (lookup_rgb)
  );

  function automatic logic [7:0] pat(input int i, input int c);
    return 8'((i * 37 + c * 101 + 11) & 255);
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One access cycle; read data sampled just before the closing edge
  task automatic acc(input logic wr, input logic [3:0] off, input logic [7:0] d, output logic [7:0] rd);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = wr; acc_off = off; acc_wdata = d;
    #4;
    rd = acc_rdata;
    @(posedge clk);
    #1;
    acc_valid = 1'b0; acc_write = 1'b0;
  endtask

  task automatic wr(input logic [3:0] off, input logic [7:0] d);
    logic [7:0] dummy;
    acc(1'b1, off, d, dummy);
  endtask

  task automatic rd_chk(input logic [3:0] off, input logic [7:0] exp, input string tag);
    logic [7:0] v;
    acc(1'b0, off, 8'h00, v);
    chk(v === exp, tag, 32'(v), 32'(exp));
  endtask

  task automatic lu_chk(input logic [7:0] idx, input int ent, input string tag);
    logic [23:0] e;
    @(negedge clk);
    lookup_idx = idx;
    #2;
    e = {m_r[ent], m_g[ent], m_b[ent]};
    chk(lookup_rgb === e, tag, 32'(lookup_rgb), 32'(e));
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [23:0] e;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset state; R11 idle read data
    #1;
    chk(acc_rdata === 8'h00, "R11 idle rdata", 32'(acc_rdata), 0);
    rd_chk(4'h0, 8'h00, "R1 widx after reset");
    rd_chk(4'h4, 8'h00, "R1 mask after reset");
    rd_chk(4'h6, 8'h03, "R1 write mode after reset");

    // R3 full table with auto-increment, write index wraps to 0
    wr(4'h8, 8'h00);
    for (int i = 0; i < 256; i++) begin
      m_r[i] = pat(i, 0); m_g[i] = pat(i, 1); m_b[i] = pat(i, 2);
      wr(4'hA, m_r[i]); wr(4'hA, m_g[i]); wr(4'hA, m_b[i]);
    end
    rd_chk(4'h0, 8'h00, "R3 write index wrap");
    rd_chk(4'h6, 8'h03, "R8 write mode code");

    // R4/R5 read back everything
    wr(4'hE, 8'h00);
    rd_chk(4'h6, 8'h00, "R4 R8 read mode code");
    for (int i = 0; i < 256; i++) begin
      rd_chk(4'h2, m_r[i], "R5 red");
      rd_chk(4'h2, m_g[i], "R5 green");
      rd_chk(4'h2, m_b[i], "R5 blue");
    end
    rd_chk(4'h2, m_r[0], "R5 read index wrap");

    // R9 color write in read mode: no store, no phase step
    wr(4'hA, 8'hEE);
    rd_chk(4'h2, m_g[0], "R9 phase held after stray write");
    rd_chk(4'h2, m_b[0], "R9 blue after stray write");

    // R2 + R9 color read in write mode returns 0 and keeps phase
    wr(4'h8, 8'h10);
    rd_chk(4'h2, 8'h00, "R9 read in write mode");
    wr(4'hA, 8'h11); wr(4'hA, 8'h22); wr(4'hA, 8'h33);
    m_r[16] = 8'h11; m_g[16] = 8'h22; m_b[16] = 8'h33;
    rd_chk(4'h0, 8'h11, "R6 widx after one triplet");

    // R2 reload mid-triplet restarts at red
    wr(4'h8, 8'h05);
    wr(4'hA, 8'hA5);
    m_r[5] = 8'hA5;
    wr(4'h8, 8'h09);
    wr(4'hA, 8'h5A); wr(4'hA, 8'h6B); wr(4'hA, 8'h7C);
    m_r[9] = 8'h5A; m_g[9] = 8'h6B; m_b[9] = 8'h7C;
    rd_chk(4'h0, 8'h0A, "R2 R6 widx after reload");

    // R3 wrap at the top entry
    wr(4'h8, 8'hFF);
    wr(4'hA, 8'h01); wr(4'hA, 8'h02); wr(4'hA, 8'h03);
    m_r[255] = 8'h01; m_g[255] = 8'h02; m_b[255] = 8'h03;
    rd_chk(4'h0, 8'h00, "R3 widx wrap at 255");

    // R4/R5 read wrap at the top entry
    wr(4'hE, 8'hFF);
    rd_chk(4'h2, 8'h01, "R5 top red");
    rd_chk(4'h2, 8'h02, "R5 top green");
    rd_chk(4'h2, 8'h03, "R5 top blue");
    rd_chk(4'h2, m_r[0], "R5 R9 entry 0 after wrap");
    wr(4'hE, 8'h05);
    rd_chk(4'h2, 8'hA5, "R2 partial red kept");
    rd_chk(4'h2, m_g[5], "R2 partial green old");

    // R7 mask, R10 lookup sweep
    wr(4'hC, 8'hFF);
    rd_chk(4'h4, 8'hFF, "R7 mask readback");
    for (int i = 0; i < 256; i++) lu_chk(8'(i), i, "R10 lookup sweep");
    wr(4'hC, 8'h0F);
    rd_chk(4'h4, 8'h0F, "R7 mask 0F");
    lu_chk(8'hF9, 9, "R10 masked lookup");
    wr(4'hC, 8'h00);
    lu_chk(8'hC3, 0, "R10 mask zero");

    // R10 same-cycle lookup and blue write to the same entry
    wr(4'hC, 8'hFF);
    @(negedge clk); lookup_idx = 8'h20;
    wr(4'h8, 8'h20);
    wr(4'hA, 8'hC1); wr(4'hA, 8'hC2);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b1; acc_off = 4'hA; acc_wdata = 8'hC3;
    #4;
    e = {8'hC1, 8'hC2, m_b[32]};
    chk(lookup_rgb === e, "R10 lookup before edge", 32'(lookup_rgb), 32'(e));
    @(posedge clk); #1;
    acc_valid = 1'b0; acc_write = 1'b0;
    e = {8'hC1, 8'hC2, 8'hC3};
    chk(lookup_rgb === e, "R10 lookup after edge", 32'(lookup_rgb), 32'(e));

    // R11 unmapped accesses
    wr(4'h0, 8'h77);
    wr(4'h4, 8'h55);
    wr(4'h3, 8'h99);
    rd_chk(4'h0, 8'h21, "R11 widx untouched");
    rd_chk(4'h4, 8'hFF, "R11 mask untouched");
    rd_chk(4'h1, 8'h00, "R11 odd offset reads 0");
    rd_chk(4'hA, 8'h00, "R11 write offset reads 0");
    acc(1'b0, 4'h6, 8'h00, v);
    chk(v === 8'h03, "R11 R8 mode untouched", 32'(v), 3);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule